// File: doc/BRIEF.md
# Serial Receive Path with Four-Character Queue

This block takes a single asynchronous serial line carrying 8N1 characters and turns it into bytes held in a small queue for a register interface. A programmable counter produces a sample tick every `baud_div + 1` clocks. Software loads `baud_div` with clock/(baud x 4) - 1, so that four ticks fall in each bit time. The line passes through a two-flop synchronizer. A sampling state machine finds the start bit, takes eight data bits least significant first, and checks the single stop bit.

Finished characters go into a four-entry queue. The head of the queue is always visible on `rd_data`, and a one-cycle `rd_pop` strobe removes it. Three level flags report the fill state: empty, full, and one slot left. Two sticky error flags record a bad stop bit and a character lost because the queue had no room. Each error flag has its own clear strobe.

Top module: `uart_rx_fifo`

## Requirements
- R1: A sample tick occurs every `baud_div + 1` clocks, so one bit time lasts 4 x (`baud_div` + 1) clocks. Characters sent at that bit time are received correctly for any divisor, including 0.
- R2: After reset, `rx_empty` is 1 and `rx_full`, `rx_one_left`, `frame_err` and `overrun_err` are 0.
- R3: The receiver accepts one start bit (low), eight data bits with bit 0 first, and one stop bit. It places the eight data bits on `rd_data` as the head of the queue, with line bit k at `rd_data[k]`.
- R4: Start is confirmed by a second low sample two ticks after the first low sample. A low pulse lasting no more than one tick period is rejected, and no character is stored.
- R5: `rx_empty` is 1 exactly when the queue holds 0 characters. `rx_full` is 1 exactly when it holds 4. `rx_one_left` is 1 exactly when it holds 3. At most one of the three is high at a time.
- R6: A character whose stop bit is sampled low sets `frame_err`. The character is still stored when there is room.
- R7: A character that completes while the queue is full, with no pop in the same cycle, sets `overrun_err` and is discarded. The stored characters are unchanged.
- R8: A character that completes in the same cycle as a pop of a full queue is stored. `overrun_err` stays 0 and the queue stays full.
- R9: A pop of an empty queue has no effect, and the fill count does not wrap.
- R10: `clr_frame_err` and `clr_overrun` each clear their own sticky flag. A new error in the same cycle wins over the clear.
- R11: Characters leave the queue in the order in which they were received.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 16 | Tick divisor, clock/(baud x 4) - 1 |
| rxd | input | 1 | Asynchronous serial line, idle high |
| rd_pop | input | 1 | Remove the head character |
| clr_frame_err | input | 1 | Clear the frame error flag |
| clr_overrun | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character of the queue |
| rx_empty | output | 1 | Queue holds no characters |
| rx_full | output | 1 | Queue holds four characters |
| rx_one_left | output | 1 | Queue holds three characters |
| frame_err | output | 1 | Sticky bad-stop-bit flag |
| overrun_err | output | 1 | Sticky lost-character flag |

## Verification
The hardest case to reach is a character that completes in the very cycle a full queue is popped, because that cycle is fixed by the hidden tick phase and the sampling schedule. The bench reaches it by setting the divisor to 0, so that a tick comes every clock. With that setting, the stop sample falls a fixed 40 clocks after the bench lowers the line. The bench counts to that clock and raises `rd_pop` for that one cycle only. The rejected start glitch and the overrun on a fifth character are also forced directly from the line.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/rxq_tick.sv
module rxq_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  function automatic logic reached(input logic [DIV_W-1:0] c, input logic [DIV_W-1:0] d);
    return c >= d;
  endfunction

  assign tick = reached(cnt, divisor);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: with a nonzero divisor, two ticks never fall on adjacent clocks
  assert_tick_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && divisor != '0) |=> (!tick || divisor == '0));
endmodule

// File: rtl/rxq_sync.sv
module rxq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '1;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rxq_sampler.sv
module rxq_sampler
  import rxq_pkg::*;
#(
  parameter int OSR    = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              line,
  output logic              done,
  output logic [DATA_W-1:0] data,
  output logic              bad_stop
);
  localparam int PH_W       = $clog2(OSR);
  localparam int BC_W       = $clog2(DATA_W);
  localparam int CONFIRM_PH = OSR / 2 - 1;
  localparam int MID_PH     = OSR - 1;

  rx_state_e         state;
  logic [PH_W-1:0]   ph;
  logic [BC_W-1:0]   bitcnt;
  logic [DATA_W-1:0] shreg;

  wire at_confirm = tick && (ph == PH_W'(CONFIRM_PH));
  wire at_mid     = tick && (ph == PH_W'(MID_PH));

  function automatic logic [DATA_W-1:0] shift_lsb_first(input logic [DATA_W-1:0] s, input logic b);
    return {b, s[DATA_W-1:1]};
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= RX_IDLE;
      ph     <= '0;
      bitcnt <= '0;
      shreg  <= '0;
    end else begin
      case (state)
        RX_IDLE: if (tick && !line) begin
          state <= RX_START;
          ph    <= '0;
        end
        RX_START: if (at_confirm) begin
          ph     <= '0;
          bitcnt <= '0;
          state  <= line ? RX_IDLE : RX_DATA;
        end else if (tick) begin
          ph <= ph + 1'b1;
        end
        RX_DATA: if (at_mid) begin
          ph    <= '0;
          shreg <= shift_lsb_first(shreg, line);
          if (bitcnt == BC_W'(DATA_W - 1)) state <= RX_STOP;
          else                              bitcnt <= bitcnt + 1'b1;
        end else if (tick) begin
          ph <= ph + 1'b1;
        end
        RX_STOP: if (at_mid) begin
          state <= RX_IDLE;
          ph    <= '0;
        end else if (tick) begin
          ph <= ph + 1'b1;
        end
        default: state <= RX_IDLE;
      endcase
    end
  end

  assign done     = (state == RX_STOP) && at_mid;
  assign data     = shreg;
  assign bad_stop = !line;

  // R3: a finished character always hands control back to idle
  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (state == RX_IDLE));
  // R4: a start that is high again at the confirm tick is dropped
  assert_glitch_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == RX_START && at_confirm && line) |=> (state == RX_IDLE && !done));
endmodule

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty,
  output logic         full,
  output logic         one_left
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;

  function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  wire do_pop = pop && (count != '0);

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= wrap_inc(wr_ptr);
      if (do_pop) rd_ptr <= wrap_inc(rd_ptr);
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head     = mem[rd_ptr];
  assign empty    = (count == '0);
  assign full     = (count == CW'(DEPTH));
  assign one_left = (count == CW'(DEPTH - 1));

  // R5: the three fill flags are mutually exclusive
  assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({empty, full, one_left}));
  // R7: no write lands on a full queue unless a read frees a slot
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R9: reading an empty queue leaves it empty
  assert_pop_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OSR    = 4,
  parameter int DEPTH  = 4,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic              rxd,
  input  logic              rd_pop,
  input  logic              clr_frame_err,
  input  logic              clr_overrun,
  output logic [DATA_W-1:0] rd_data,
  output logic              rx_empty,
  output logic              rx_full,
  output logic              rx_one_left,
  output logic              frame_err,
  output logic              overrun_err
);
  logic              tick, line_s;
  logic              char_done, char_bad_stop;
  logic [DATA_W-1:0] char_data;

  rxq_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .divisor(baud_div), .tick(tick));

  rxq_sync #(.STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(rxd), .dout(line_s));

  rxq_sampler #(.OSR(OSR), .DATA_W(DATA_W)) u_samp (
    .clk(clk), .rst_n(rst_n), .tick(tick), .line(line_s),
    .done(char_done), .data(char_data), .bad_stop(char_bad_stop));

  wire q_push   = char_done && (!rx_full || rd_pop);
  wire ovr_evt  = char_done && rx_full && !rd_pop;
  wire ferr_evt = char_done && char_bad_stop;

  rxq_fifo #(.DEPTH(DEPTH), .W(DATA_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(q_push), .wdata(char_data), .pop(rd_pop),
    .head(rd_data), .empty(rx_empty), .full(rx_full), .one_left(rx_one_left));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_err   <= 1'b0;
      overrun_err <= 1'b0;
    end else begin
      if (ferr_evt)           frame_err <= 1'b1;
      else if (clr_frame_err) frame_err <= 1'b0;
      if (ovr_evt)            overrun_err <= 1'b1;
      else if (clr_overrun)   overrun_err <= 1'b0;
    end
  end

  // R6: a bad stop bit always leaves the flag set
  assert_frame_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ferr_evt |=> frame_err);
  // R7: a character lost to a full queue always leaves the flag set
  assert_overrun_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> overrun_err);
  // R8: completing into a full queue while it is read keeps it full
  assert_swap_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_done && rx_full && rd_pop) |=> rx_full);
endmodule

// File: tb/tb_uart_rx_fifo.sv
module tb_uart_rx_fifo;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] baud_div;
  logic        rxd, rd_pop, clr_frame_err, clr_overrun;
  logic [7:0]  rd_data;
  logic        rx_empty, rx_full, rx_one_left, frame_err, overrun_err;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_rx_fifo dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rxd(rxd), .rd_pop(rd_pop),
    .clr_frame_err(clr_frame_err), .clr_overrun(clr_overrun), .rd_data(rd_data),
    .rx_empty(rx_empty), .rx_full(rx_full), .rx_one_left(rx_one_left),
    .frame_err(frame_err), .overrun_err(overrun_err));

  // {divisor, data byte, stop bit level}
  localparam logic [16:0] VEC [8] = '{
    {8'd3, 8'h55, 1'b1}, {8'd0, 8'hA3, 1'b1}, {8'd5, 8'h00, 1'b1},
    {8'd3, 8'hFF, 1'b1}, {8'd1, 8'h80, 1'b1}, {8'd2, 8'h01, 1'b1},
    {8'd3, 8'h3C, 1'b0}, {8'd0, 8'hC5, 1'b1}};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic bit_wait();
    repeat (4 * (int'(baud_div) + 1)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input logic stop_lvl);
    rxd = 1'b0;
    bit_wait();
    for (int i = 0; i < 8; i++) begin
      rxd = d[i];
      bit_wait();
    end
    rxd = stop_lvl;
    bit_wait();
    rxd = 1'b1;
    bit_wait();
    bit_wait();
  endtask

  task automatic pop_one();
    rd_pop = 1'b1;
    @(negedge clk);
    rd_pop = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; rxd = 1'b1; rd_pop = 1'b0; baud_div = 16'd3;
    clr_frame_err = 1'b0; clr_overrun = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R2 empty", rx_empty, 1);
    chk("R2 full", rx_full, 0);
    chk("R2 one_left", rx_one_left, 0);
    chk("R2 frame_err", frame_err, 0);
    chk("R2 overrun_err", overrun_err, 0);

    // table walk: R1 divisors, R3 data, R6 stop bit
    for (int i = 0; i < 8; i++) begin
      baud_div = 16'(VEC[i][16:9]);
      send(VEC[i][8:1], VEC[i][0]);
      chk("R3 not empty", rx_empty, 0);
      chk("R1 R3 data", rd_data, VEC[i][8:1]);
      chk("R6 frame_err", frame_err, !VEC[i][0]);
      if (frame_err) begin
        clr_frame_err = 1'b1;
        @(negedge clk);
        clr_frame_err = 1'b0;
        chk("R10 frame clear", frame_err, 0);
      end
      pop_one();
      chk("R11 drained", rx_empty, 1);
    end

    // R4: one-tick low glitch is not a start
    baud_div = 16'd3;
    rxd = 1'b0;
    repeat (4) @(negedge clk);
    rxd = 1'b1;
    repeat (100) @(negedge clk);
    chk("R4 no char", rx_empty, 1);
    chk("R4 no frame", frame_err, 0);
    send(8'h5A, 1'b1);
    chk("R4 recover", rd_data, 8'h5A);
    pop_one();

    // R9: pop of an empty queue is ignored
    pop_one();
    chk("R9 still empty", rx_empty, 1);
    baud_div = 16'd1;
    send(8'h11, 1'b1);
    send(8'h22, 1'b1);
    send(8'h33, 1'b1);
    chk("R5 R9 one_left", rx_one_left, 1);
    chk("R5 not full", rx_full, 0);
    send(8'h44, 1'b1);
    chk("R5 full", rx_full, 1);
    chk("R5 one_left low", rx_one_left, 0);
    chk("R7 no overrun yet", overrun_err, 0);

    // R7: fifth character dropped
    send(8'hEE, 1'b1);
    chk("R7 overrun", overrun_err, 1);
    chk("R7 full", rx_full, 1);
    chk("R7 head kept", rd_data, 8'h11);
    clr_overrun = 1'b1;
    @(negedge clk);
    clr_overrun = 1'b0;
    chk("R10 overrun clear", overrun_err, 0);

    // R8: stop sample lands 40 clocks after the start edge at divisor 0
    baud_div = 16'd0;
    fork
      send(8'h77, 1'b1);
      begin
        repeat (40) @(negedge clk);
        pop_one();
      end
    join
    chk("R8 no overrun", overrun_err, 0);
    chk("R8 still full", rx_full, 1);
    chk("R11 order 1", rd_data, 8'h22); pop_one();
    chk("R11 order 2", rd_data, 8'h33); pop_one();
    chk("R11 order 3", rd_data, 8'h44); pop_one();
    chk("R8 R7 new char", rd_data, 8'h77); pop_one();
    chk("R5 empty at end", rx_empty, 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule